// File: doc/BRIEF.md
# Keyed Configuration Blob Port

This block sits on a simple register bus and lets a host processor fetch small configuration records by key. The host writes a 16-bit key to a selector register and then pulls the chosen record out of a data register, one byte or several bytes per access. Each access moves the block's internal byte pointer forward, so a wide access works as a short burst of consecutive record bytes and not as a read of one word register.

Three records live inside. The first is a fixed four-byte signature that lets software confirm the block is present. The second is a four-byte revision word that currently reads as zero. The third is a small writable scratch record held in flops. Any other key selects nothing, and such reads return zero. A request is accepted when `reqValid` and `reqReady` are both high. The response comes back one cycle later, and the block will not take a request in that response cycle.

Top module: `keyed_blob_regs`

## Requirements
- R1: After reset, key 0x0000 is selected at byte offset 0, `reqReady` is high, `rspValid` is low and `rspRdata` is zero.
- R2: An accepted request raises `rspValid` for exactly the next cycle. `reqReady` is low in that cycle, so two requests are never accepted in consecutive cycles. `rspRdata` is zero whenever `rspValid` is low.
- R3: A write of size code 1 to address 8 selects a key. `reqWdata[7:0]` is the high key byte and `reqWdata[15:8]` is the low key byte. The write resets the offset to 0. A selector write of any other size is ignored.
- R4: The data register exists only at address 0. A data access at any address other than 0 or 8 returns zero and leaves the offset and the records unchanged.
- R5: Size codes 0, 1, 2 and 3 move 1, 2, 4 and 8 bytes. Lane i (bits 8i+7..8i) carries the byte at offset+i. Lanes at or above the size read as zero.
- R6: Every data-register read or write advances the offset by its size in bytes.
- R7: Key 0x0000 yields the signature bytes 0x43, 0x46, 0x47, 0x42 at offsets 0 to 3.
- R8: Key 0x0001 yields four zero bytes, so a 4-byte read of it returns the little-endian value 0.
- R9: Bytes beyond a record's length, and all bytes under an unknown key, read as zero. The offset still advances.
- R10: Key 0x0102 selects a writable 16-byte record. A data write stores lane i at offset+i when strobe bit i is set and i is below the access size.
- R11: Data writes to a read-only record, and the bytes of a write that fall beyond the writable record's end, are ignored. A write response carries zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block can accept a request this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Register byte address (0 = data, 8 = selector) |
| reqSize | input | 2 | Access size code: 1 << code bytes |
| reqWdata | input | 64 | Write data, lane i at bits 8i+7..8i |
| reqStrb | input | 8 | Per-lane write strobes |
| rspValid | output | 1 | Response valid, one cycle after acceptance |
| rspRdata | output | 64 | Read data, zero when no read response |

## Verification
The hardest situation to reach is a wide write that straddles the end of the writable record, where some lanes must land and the rest must vanish. The stimulus walks the pointer through the record with a rotating mix of access sizes and partial strobes, so writes end up at unaligned offsets such as 14. It then reselects the key and reads everything back, past the end, at every size. A bench model of the record, the key and the pointer predicts each returned lane, and a byte-swapped selector write is used to tell big-endian key decoding apart from little-endian decoding.

// File: rtl/blob_pkg.sv
package blob_pkg;
  // Data bus is 8 byte lanes; size codes 0..3 span 1..8 bytes
  localparam int BLOB_LANES = 8;
  localparam int NB_W       = $clog2(BLOB_LANES) + 1;

  typedef struct packed {
    logic            selWr;   // accepted selector write
    logic            dataRd;  // accepted data-register read
    logic            dataWr;  // accepted data-register write
    logic [NB_W-1:0] nBytes;  // bytes moved by this access
  } blobStb_t;
endpackage

// File: rtl/blob_ctl.sv
module blob_ctl
  import blob_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_ADDR = 0,
  parameter int SEL_ADDR  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  output logic              reqReady,
  output logic              rspValid,
  output blobStb_t          stb
);
  logic accept, atData, atSel;

  assign reqReady = !rspValid;
  assign accept   = reqValid && reqReady;
  assign atData   = (reqAddr == ADDR_W'(DATA_ADDR));
  assign atSel    = (reqAddr == ADDR_W'(SEL_ADDR));

  always_comb begin
    stb.selWr  = accept && reqWrite && atSel && (reqSize == 2'd1);
    stb.dataRd = accept && !reqWrite && atData;
    stb.dataWr = accept && reqWrite && atData;
    stb.nBytes = NB_W'(1) << reqSize;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rspValid <= 1'b0;
    else       rspValid <= accept;
  end
endmodule

// File: rtl/blob_dp.sv
module blob_dp
  import blob_pkg::*;
#(
  parameter int          OFF_W   = 16,
  parameter int          SCR_LEN = 16,
  parameter logic [15:0] SCR_KEY = 16'h0102,
  parameter logic [31:0] SIG     = 32'h43464742
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  blobStb_t                stb,
  input  logic [BLOB_LANES*8-1:0] wdata,
  input  logic [BLOB_LANES-1:0]   wstrb,
  output logic [BLOB_LANES*8-1:0] rdata
);
  localparam int SCR_AW = (SCR_LEN > 1) ? $clog2(SCR_LEN) : 1;
  localparam int IDX_W  = OFF_W + 1;

  logic [15:0]             selKey;
  logic [OFF_W-1:0]        offset;
  logic [7:0]              scrMem [SCR_LEN];
  logic [IDX_W-1:0]        laneIdx [BLOB_LANES];
  logic [BLOB_LANES-1:0]   laneWe;
  logic [BLOB_LANES*8-1:0] rdNext;
  logic                    isSig, isScr;
  logic [IDX_W-1:0]        offSum;

  assign isSig = (selKey == 16'h0000);
  assign isScr = (selKey == SCR_KEY);

  for (genvar g = 0; g < BLOB_LANES; g++) begin : g_lane
    logic inSize;
    assign laneIdx[g] = {1'b0, offset} + IDX_W'(g);
    assign inSize     = NB_W'(g) < stb.nBytes;
    assign laneWe[g]  = stb.dataWr && isScr && inSize && wstrb[g]
                        && (laneIdx[g] < IDX_W'(SCR_LEN));
    always_comb begin
      rdNext[8*g +: 8] = 8'h00;
      if (inSize) begin
        if (isSig && laneIdx[g] < IDX_W'(4))
          rdNext[8*g +: 8] = SIG[8*(3 - laneIdx[g][1:0]) +: 8];
        else if (isScr && laneIdx[g] < IDX_W'(SCR_LEN))
          rdNext[8*g +: 8] = scrMem[laneIdx[g][SCR_AW-1:0]];
      end
    end
  end

  assign offSum = {1'b0, offset} + IDX_W'(stb.nBytes);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selKey <= 16'h0000;
      offset <= '0;
      rdata  <= '0;
    end else begin
      rdata <= stb.dataRd ? rdNext : '0;
      if (stb.selWr) begin
        selKey <= {wdata[7:0], wdata[15:8]};
        offset <= '0;
      end else if (stb.dataRd || stb.dataWr) begin
        offset <= offSum[OFF_W] ? '1 : offSum[OFF_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int j = 0; j < SCR_LEN; j++) scrMem[j] <= 8'h00;
    end else begin
      for (int g = 0; g < BLOB_LANES; g++)
        if (laneWe[g]) scrMem[laneIdx[g][SCR_AW-1:0]] <= wdata[8*g +: 8];
    end
  end
endmodule

// File: rtl/keyed_blob_regs.sv
module keyed_blob_regs
  import blob_pkg::*;
#(
  parameter int          ADDR_W  = 4,
  parameter int          OFF_W   = 16,
  parameter int          SCR_LEN = 16,
  parameter logic [15:0] SCR_KEY = 16'h0102
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic [63:0]       reqWdata,
  input  logic [7:0]        reqStrb,
  output logic              rspValid,
  output logic [63:0]       rspRdata
);
  blobStb_t stb;

  blob_ctl #(.ADDR_W(ADDR_W)) u_ctl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqSize(reqSize), .reqReady(reqReady),
    .rspValid(rspValid), .stb(stb)
  );

  blob_dp #(.OFF_W(OFF_W), .SCR_LEN(SCR_LEN), .SCR_KEY(SCR_KEY)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wdata(reqWdata),
    .wstrb(reqStrb), .rdata(rspRdata)
  );
endmodule

// File: rtl/keyed_blob_regs_chk.sv
module keyed_blob_regs_chk #(
  parameter int          ADDR_W  = 4,
  parameter logic [15:0] SCR_KEY = 16'h0102
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              reqWrite,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [1:0]        reqSize,
  input logic [63:0]       reqWdata,
  input logic [7:0]        reqStrb,
  input logic              rspValid,
  input logic [63:0]       rspRdata
);
  logic        acc, keyKnown;
  logic [15:0] newKey;

  assign acc    = reqValid && reqReady;
  assign newKey = {reqWdata[7:0], reqWdata[15:8]};

  always_ff @(posedge clk) begin
    if (!rstN) keyKnown <= 1'b1;
    else if (acc && reqWrite && reqAddr == ADDR_W'(8) && reqSize == 2'd1)
      keyKnown <= (newKey == 16'h0000) || (newKey == 16'h0001) || (newKey == SCR_KEY);
  end

  assert_rsp_next_R2: assert property (@(posedge clk) disable iff (!rstN)
    acc |=> rspValid && !reqReady);
  assert_no_b2b_R2: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);
  assert_idle_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> rspRdata == 64'd0);
  assert_narrow_lanes_R5: assert property (@(posedge clk) disable iff (!rstN)
    (acc && !reqWrite && reqSize == 2'd0) |=> rspRdata[63:8] == 56'd0);
  assert_unknown_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    (acc && !reqWrite && reqAddr == ADDR_W'(0) && !keyKnown) |=> rspRdata == 64'd0);
  assert_write_zero_R11: assert property (@(posedge clk) disable iff (!rstN)
    (acc && reqWrite) |=> rspRdata == 64'd0);
endmodule

bind keyed_blob_regs keyed_blob_regs_chk #(.ADDR_W(ADDR_W), .SCR_KEY(SCR_KEY)) u_chk (.*);

// File: tb/keyed_blob_regs_tb.sv
module keyed_blob_regs_tb;
  localparam logic [15:0] SCR_KEY = 16'h0102;
  localparam int          SCR_LEN = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [3:0]  reqAddr = '0;
  logic [1:0]  reqSize = '0;
  logic [63:0] reqWdata = '0;
  logic [7:0]  reqStrb = '0;
  logic        reqReady, rspValid;
  logic [63:0] rspRdata;

  int nRun = 0, nFail = 0;
  logic [15:0] bKey;
  int          bOff;
  logic [7:0]  expMem [SCR_LEN];

  always #5 clk = ~clk;

  keyed_blob_regs u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqSize(reqSize),
    .reqWdata(reqWdata), .reqStrb(reqStrb), .rspValid(rspValid),
    .rspRdata(rspRdata)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] expByte(input logic [15:0] key, input int idx);
    logic [31:0] sig = 32'h43464742;
    if (key == 16'h0000 && idx < 4) return sig[8*(3-idx) +: 8];
    if (key == SCR_KEY && idx < SCR_LEN) return expMem[idx];
    return 8'h00;
  endfunction

  task automatic doAcc(input logic wr, input logic [3:0] addr, input logic [1:0] sz,
                       input logic [63:0] wd, input logic [7:0] st, output logic [63:0] rd);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = addr; reqSize = sz;
    reqWdata = wd; reqStrb = st;
    @(negedge clk);
    reqValid = 1'b0;
    check("R2 rspValid after accept", 64'(rspValid), 64'd1);
    check("R2 reqReady low in response cycle", 64'(reqReady), 64'd0);
    rd = rspRdata;
  endtask

  task automatic selRaw(input logic [15:0] wd16);
    logic [63:0] rd;
    doAcc(1'b1, 4'd8, 2'd1, {48'd0, wd16}, 8'hFF, rd);
    bKey = {wd16[7:0], wd16[15:8]};
    bOff = 0;
  endtask

  task automatic selKey(input logic [15:0] key);
    selRaw({key[7:0], key[15:8]});
  endtask

  task automatic rdData(input logic [1:0] sz, input string tag);
    logic [63:0] rd, exp;
    int n = 1 << sz;
    exp = '0;
    for (int i = 0; i < n; i++) exp[8*i +: 8] = expByte(bKey, bOff + i);
    doAcc(1'b0, 4'd0, sz, 64'd0, 8'h00, rd);
    check(tag, rd, exp);
    bOff += n;
  endtask

  task automatic wrData(input logic [1:0] sz, input logic [63:0] wd, input logic [7:0] st);
    logic [63:0] rd;
    int n = 1 << sz;
    for (int i = 0; i < n; i++)
      if (bKey == SCR_KEY && st[i] && bOff + i < SCR_LEN) expMem[bOff + i] = wd[8*i +: 8];
    doAcc(1'b1, 4'd0, sz, wd, st, rd);
    check("R11 write response data zero", rd, 64'd0);
    bOff += n;
  endtask

  initial begin
    #200000;
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    logic [63:0] rd;
    for (int j = 0; j < SCR_LEN; j++) expMem[j] = 8'h00;
    bKey = 16'h0000; bOff = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 reqReady after reset", 64'(reqReady), 64'd1);
    check("R1 rspValid after reset", 64'(rspValid), 64'd0);
    check("R1 rdata after reset", rspRdata, 64'd0);
    rdData(2'd0, "R1 default key 0 offset 0");

    // R7 R9 R6 signature bytewise, past its end
    selKey(16'h0000);
    for (int k = 0; k < 6; k++) rdData(2'd0, "R7 R9 signature byte");

    // R5 R6 every size, two reads each
    for (int sz = 0; sz < 4; sz++) begin
      selKey(16'h0000);
      rdData(2'(sz), "R5 lane order first read");
      rdData(2'(sz), "R6 lane order second read");
    end

    // R8 revision word
    selKey(16'h0001);
    rdData(2'd2, "R8 revision word zero");
    rdData(2'd2, "R8 revision past end");

    // R3 R9 byte-swapped key is unknown
    selRaw(16'h0102);
    rdData(2'd3, "R9 unknown key reads zero");

    // R10 R6 scratch fill with rotating sizes and strobes
    selRaw(16'h0201);
    check("R3 big-endian key decode", 64'(bKey), 64'(SCR_KEY));
    for (int s = 0; s < 6; s++) begin
      logic [63:0] pat;
      for (int i = 0; i < 8; i++) pat[8*i +: 8] = 8'(16 * s + 3 * i + 1);
      wrData(2'(s % 4), pat, (s == 3) ? 8'hA5 : 8'hFF);
    end
    // R11 straddling end: offset 14, 8 bytes
    selKey(SCR_KEY);
    for (int i = 0; i < 7; i++) wrData(2'd1, 64'd0, 8'h00);
    wrData(2'd3, 64'hF7F6F5F4F3F2F1F0, 8'hFF);
    for (int sz = 0; sz < 4; sz++) begin
      selKey(SCR_KEY);
      for (int r = 0; r < 24 / (1 << sz) + 1; r++) rdData(2'(sz), "R10 scratch readback");
    end

    // R11 write to read-only signature ignored
    selKey(16'h0000);
    wrData(2'd2, 64'h11223344, 8'hFF);
    selKey(16'h0000);
    rdData(2'd2, "R11 signature unchanged");

    // R4 off-offset data access ignored
    selKey(16'h0000);
    doAcc(1'b0, 4'd4, 2'd0, 64'd0, 8'h00, rd);
    check("R4 non-zero address reads zero", rd, 64'd0);
    selKey(SCR_KEY);
    doAcc(1'b1, 4'd4, 2'd3, 64'hFFFFFFFFFFFFFFFF, 8'hFF, rd);
    rdData(2'd3, "R4 no offset move and no write");

    // R3 selector with wrong size ignored
    selKey(16'h0000);
    rdData(2'd0, "R3 first byte");
    doAcc(1'b1, 4'd8, 2'd0, 64'h0100, 8'hFF, rd);
    rdData(2'd0, "R3 narrow selector write ignored");

    // R2 idle response cycle
    @(negedge clk);
    check("R2 rspValid drops", 64'(rspValid), 64'd0);
    check("R2 rdata zero when idle", rspRdata, 64'd0);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule